// File: doc/BRIEF.md
# Serial DAC Register Access Controller

This block sits on the host side of a serial DAC and turns single register requests into 24-bit serial frames. A request names a register (7-bit address), says whether it is a read or a write, and carries 16 bits of write data. A write goes out as one frame. A read takes two frames. The first frame carries the read command. The second frame sends a no-operation word while the device shifts back the register contents.

Each frame is framed by an active-low select. The serial clock idles low. Outgoing data changes on the clock's falling edge and incoming data is sampled on its rising edge. The serial clock runs at the system clock divided by twice the parameter `HALF_CYC`. While the controller is working it raises `busy`, and it drops any request that arrives during that time. A finished read is reported through `rd_data` together with a single-cycle `rd_valid` pulse.

Top module: `dac_reg_link`

## Requirements
- R1: Out of reset `cs_n` is 1, and `sclk`, `mosi`, `busy` and `rd_valid` are all 0.
- R2: Each frame has exactly 24 rising edges of `sclk`, and `cs_n` stays low for the whole frame. Whenever `cs_n` is high, `sclk` and `mosi` are both low, so `sclk` is also low at each edge of `cs_n`.
- R3: Frame bits are sent MSB first. Bit 23 is the read flag (1 = read). Bits 22:16 hold the register address. Bits 15:0 hold the data word, which is the write data for a write and zero for a read command.
- R4: `mosi` changes only while `sclk` is low, so it holds steady across every high phase of `sclk`.
- R5: A read issues exactly two frames. The first is the read command. The second carries 24 zero bits.
- R6: After a read, `rd_data` equals the low 16 bits of the 24 bits sampled on `miso` during the second frame. `rd_valid` is high for exactly one cycle, and that cycle is the one in which `cs_n` has just returned high after that frame.
- R7: `busy` goes high the cycle after a request is accepted and stays high until `cs_n` rises after the last frame. A request with `req_valid` high while `busy` is high is ignored: it produces no frame and changes no register.
- R8: Before every falling edge of `cs_n`, `cs_n` has been high for at least `HALF_CYC` system clock cycles, and this includes the gap between the two frames of a read.
- R9: A write issues exactly one frame.
- R10: Each high phase of `sclk` lasts exactly `HALF_CYC` system clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe. Taken only when `busy` is low |
| req_read | input | 1 | 1 = read request, 0 = write request |
| req_addr | input | 7 | Register address |
| req_wdata | input | 16 | Data for a write request |
| busy | output | 1 | High while a transaction is in progress |
| rd_data | output | 16 | Data returned by the last read |
| rd_valid | output | 1 | One-cycle strobe marking new `rd_data` |
| cs_n | output | 1 | Active-low device select |
| sclk | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data to the device |
| miso | input | 1 | Serial data from the device |

## Verification
The bench talks to a behavioural register-file device and checks write-then-read round trips. A read that used a single frame would return the device's idle output instead of the stored value. A second frame that did not carry zeros would be taken by the device as a new command. The bench sends a write while the block is busy and then reads back the targeted register. A controller that did not drop the extra request would produce a third frame or overwrite that register. The bench also times the select gap between the two read frames and the length of each clock high phase, so a missing or short gap is caught. Finally it counts the cycles `rd_valid` stays high, which catches a strobe that lasts too long or is given too early.

// File: rtl/dac_reg_link.sv
module dac_reg_link #(
  parameter int HALF_CYC = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        req_read,
  input  logic [6:0]  req_addr,
  input  logic [15:0] req_wdata,
  output logic        busy,
  output logic [15:0] rd_data,
  output logic        rd_valid,
  output logic        cs_n,
  output logic        sclk,
  output logic        mosi,
  input  logic        miso
);
  localparam int CW        = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam int FRAME_LEN = 24;
  localparam int LAST_HALF = 2 * FRAME_LEN - 1;

  typedef enum logic [1:0] {S_IDLE, S_LEAD, S_XFER} state_t;

  state_t      st;
  logic [CW-1:0] cnt;
  logic [5:0]  half;
  logic [23:0] tx_sh;
  logic [23:0] rx_sh;
  logic        is_rd;
  logic        second;

  wire tick   = (cnt == CW'(HALF_CYC - 1));
  wire accept = req_valid && (st == S_IDLE);

  assign busy = (st != S_IDLE);
  assign mosi = !cs_n && tx_sh[23];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cnt      <= '0;
      half     <= '0;
      tx_sh    <= '0;
      rx_sh    <= '0;
      is_rd    <= 1'b0;
      second   <= 1'b0;
      cs_n     <= 1'b1;
      sclk     <= 1'b0;
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= 1'b0;
      if (st != S_IDLE) cnt <= tick ? '0 : cnt + 1'b1;
      case (st)
        S_IDLE: if (accept) begin
          st     <= S_LEAD;
          cnt    <= '0;
          is_rd  <= req_read;
          second <= 1'b0;
          tx_sh  <= {req_read, req_addr, req_read ? 16'h0000 : req_wdata};
        end
        S_LEAD: if (tick) begin
          cs_n <= 1'b0;
          half <= '0;
          st   <= S_XFER;
        end
        S_XFER: if (tick) begin
          if (!half[0]) begin
            sclk  <= 1'b1;
            rx_sh <= {rx_sh[22:0], miso};
            half  <= half + 1'b1;
          end else begin
            sclk <= 1'b0;
            if (half == 6'(LAST_HALF)) begin
              cs_n <= 1'b1;
              if (is_rd && !second) begin
                second <= 1'b1;
                tx_sh  <= '0;
                st     <= S_LEAD;
              end else begin
                st <= S_IDLE;
                if (is_rd) begin
                  rd_data  <= rx_sh[15:0];
                  rd_valid <= 1'b1;
                end
              end
            end else begin
              tx_sh <= {tx_sh[22:0], 1'b0};
              half  <= half + 1'b1;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module dac_reg_link_chk #(
  parameter int HALF_CYC = 2
) (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic busy,
  input logic rd_valid,
  input logic cs_n,
  input logic sclk,
  input logic mosi
);
  int unsigned gap;

  always_ff @(posedge clk) begin
    if (!rst_n)    gap <= 0;
    else if (cs_n) gap <= (gap < 1000) ? gap + 1 : gap;
    else           gap <= 0;
  end

  AST_IDLE_CLK_LOW:   assert property (@(posedge clk) disable iff (!rst_n) cs_n |-> !sclk);                 // R2
  AST_MOSI_HELD_HIGH: assert property (@(posedge clk) disable iff (!rst_n) (sclk && $past(sclk)) |-> $stable(mosi)); // R4
  AST_RDV_SINGLE:     assert property (@(posedge clk) disable iff (!rst_n) rd_valid |=> !rd_valid);         // R6
  AST_RDV_AT_CS_RISE: assert property (@(posedge clk) disable iff (!rst_n) rd_valid |-> $rose(cs_n));       // R6
  AST_BUSY_IN_FRAME:  assert property (@(posedge clk) disable iff (!rst_n) !cs_n |-> busy);                 // R7
  AST_ACCEPT_BUSY:    assert property (@(posedge clk) disable iff (!rst_n) (req_valid && !busy) |=> busy);  // R7
  AST_CS_GAP:         assert property (@(posedge clk) disable iff (!rst_n) $fell(cs_n) |-> (gap >= HALF_CYC)); // R8
endmodule

bind dac_reg_link dac_reg_link_chk #(.HALF_CYC(HALF_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .busy(busy),
  .rd_valid(rd_valid), .cs_n(cs_n), .sclk(sclk), .mosi(mosi)
);

// File: tb/dac_reg_link_test.sv
module dac_reg_link_test;
  localparam int DIV = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_read = 1'b0;
  logic [6:0]  req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        busy, rd_valid, cs_n, sclk, mosi, miso;
  logic [15:0] rd_data;

  always #4 clk = ~clk;

  dac_reg_link #(.HALF_CYC(DIV)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_read(req_read),
    .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy),
    .rd_data(rd_data), .rd_valid(rd_valid), .cs_n(cs_n), .sclk(sclk),
    .mosi(mosi), .miso(miso)
  );

  int tests = 0;
  int fails = 0;

  logic [15:0] mem [0:127];
  logic [23:0] in_sh, out_sh, last_f, prev_f;
  logic        pend;
  logic [6:0]  pend_addr;
  logic        p_cs = 1'b1, p_sclk = 1'b0, seen_frame = 1'b0;
  int frames = 0, bits = 0, last_bits = 0;
  int idle_bad = 0, busy_bad = 0, half_bad = 0, hi_run = 0;
  int gap_run = 0, min_gap = 1000;
  int rdv_cnt = 0, rdv_run = 0, rdv_max = 0;
  logic [15:0] last_rd = '0;

  assign miso = out_sh[23];

  initial begin
    for (int i = 0; i < 128; i++) mem[i] = 16'h0000;
    in_sh = '0; out_sh = '0; last_f = '0; prev_f = '0;
    pend = 1'b0; pend_addr = '0;
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (!cs_n && p_cs) begin
        bits = 0; in_sh = '0;
        out_sh = pend ? {8'h00, mem[pend_addr]} : 24'h0;
        if (seen_frame && gap_run < min_gap) min_gap = gap_run;
        gap_run = 0;
      end
      if (!cs_n && sclk && !p_sclk) begin
        in_sh = {in_sh[22:0], mosi};
        bits++;
      end
      if (!cs_n && !sclk && p_sclk) out_sh = {out_sh[22:0], 1'b0};
      if (cs_n && !p_cs) begin
        frames++; seen_frame = 1'b1;
        prev_f = last_f; last_f = in_sh; last_bits = bits;
        if (pend) pend = 1'b0;
        else if (in_sh[23]) begin pend = 1'b1; pend_addr = in_sh[22:16]; end
        else mem[in_sh[22:16]] = in_sh[15:0];
      end
      if (cs_n) gap_run++;
      if (cs_n && (sclk || mosi)) idle_bad++;
      if (!cs_n && !busy) busy_bad++;
      if (sclk) hi_run++;
      else begin
        if (p_sclk && hi_run != DIV) half_bad++;
        hi_run = 0;
      end
      if (rd_valid) begin
        rdv_run++; last_rd = rd_data;
        if (rdv_run == 1) rdv_cnt++;
        if (rdv_run > rdv_max) rdv_max = rdv_run;
      end else rdv_run = 0;
    end
    p_cs = cs_n; p_sclk = sclk;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send(input bit rd, input logic [6:0] a, input logic [15:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_read = rd; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_done();
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(cs_n === 1'b1, "R1 cs_n", 32'(cs_n), 1);
    chk(sclk === 1'b0, "R1 sclk", 32'(sclk), 0);
    chk(mosi === 1'b0, "R1 mosi", 32'(mosi), 0);
    chk(busy === 1'b0, "R1 busy", 32'(busy), 0);
    chk(rd_valid === 1'b0, "R1 rd_valid", 32'(rd_valid), 0);
  endtask

  task automatic t_write(input logic [6:0] a, input logic [15:0] d);
    int f0 = frames, r0 = rdv_cnt;
    send(1'b0, a, d);
    chk(busy === 1'b1, "R7 busy after accept", 32'(busy), 1);
    wait_done();
    chk(frames == f0 + 1, "R9 write frame count", 32'(frames - f0), 1);
    chk(last_f == {1'b0, a, d}, "R3 write frame bits", 32'(last_f), 32'({1'b0, a, d}));
    chk(last_bits == 24, "R2 clocks per frame", 32'(last_bits), 24);
    chk(rdv_cnt == r0, "R6 no strobe on write", 32'(rdv_cnt - r0), 0);
  endtask

  task automatic t_read(input logic [6:0] a, input logic [15:0] exp);
    int f0 = frames, r0 = rdv_cnt;
    send(1'b1, a, 16'hFFFF);
    wait_done();
    chk(frames == f0 + 2, "R5 read frame count", 32'(frames - f0), 2);
    chk(prev_f == {1'b1, a, 16'h0000}, "R3 read command bits", 32'(prev_f), 32'({1'b1, a, 16'h0000}));
    chk(last_f == 24'h0, "R5 second frame zero", 32'(last_f), 0);
    chk(last_bits == 24, "R2 clocks in second frame", 32'(last_bits), 24);
    chk(rdv_cnt == r0 + 1, "R6 one strobe", 32'(rdv_cnt - r0), 1);
    chk(last_rd == exp, "R6 read data", 32'(last_rd), 32'(exp));
  endtask

  task automatic t_ignore_busy();
    int f0 = frames;
    send(1'b0, 7'h11, 16'h1357);
    repeat (10) @(negedge clk);
    chk(busy === 1'b1, "R7 busy mid frame", 32'(busy), 1);
    send(1'b0, 7'h22, 16'hDEAD);
    wait_done();
    chk(frames == f0 + 1, "R7 ignored request made no frame", 32'(frames - f0), 1);
    t_read(7'h22, 16'h0000);
    t_read(7'h11, 16'h1357);
  endtask

  task automatic t_monitors();
    chk(idle_bad == 0, "R2 lines low while deselected", 32'(idle_bad), 0);
    chk(busy_bad == 0, "R7 busy during frames", 32'(busy_bad), 0);
    chk(half_bad == 0, "R10 clock high phase", 32'(half_bad), 0);
    chk(min_gap >= DIV, "R8 select gap", 32'(min_gap), DIV);
    chk(rdv_max == 1, "R6 strobe width", 32'(rdv_max), 1);
    chk(busy === 1'b0 && cs_n === 1'b1, "R7 idle at end", 32'({busy, cs_n}), 32'b01);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_write(7'h04, 16'h4000);
    t_read(7'h04, 16'h4000);
    t_write(7'h00, 16'h0080);
    t_write(7'h7F, 16'hA5C3);
    t_read(7'h7F, 16'hA5C3);
    t_read(7'h00, 16'h0080);
    t_read(7'h33, 16'h0000);
    t_write(7'h55, 16'hFFFF);
    t_read(7'h55, 16'hFFFF);
    t_ignore_busy();
    t_monitors();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule